// File: doc/BRIEF.md
# DS3 Idle Signal Detector

This block looks at a DS3 receive bit stream that framing logic upstream has already aligned. Each received bit arrives with three companions: a strobe that marks it valid, its index within the 4760-bit M-frame, and a flag that says whether the framer is in frame. The M-frame has seven subframes. Each subframe has eight blocks, and each block is one overhead bit followed by 84 payload bits. In an idle signal the payload runs through a repeating 1100 sequence, and that sequence starts again at "11" after every overhead bit.

The detector compares every payload bit with the 1100 sequence. It counts the 4-bit groups that hold at least one wrong bit, and it records whether any of the three stuffing-control bits that must be zero in the third subframe arrived as one. When the last bit of a frame is accepted, a single registered status output is written. It reads 1 when that frame passed and 0 when it failed. The output is not latched, so one failing frame clears it. Checking the frame alignment words and the parity bits is left to other logic.

Top module: `ds3_idle_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `idle` is 0.
- R2: Block offset is `bit_pos mod 85`. Offset 0 is an overhead bit. Payload index k = offset−1 expects a 1 when k mod 4 is 0 or 1, and a 0 when k mod 4 is 2 or 3. A frame from `bit_pos` 0 to 4759 that matches everywhere, with all three control bits zero, sets `idle` to 1.
- R3: A 4-bit group counts as errored once, however many of its four bits are wrong.
- R4: A frame with at most 5 errored groups still sets `idle` to 1, provided the control bits are zero.
- R5: A frame with 6 or more errored groups sets `idle` to 0.
- R6: Block index is `bit_pos div 85`. The overhead bits of blocks 18, 20 and 22 (`bit_pos` 1530, 1700 and 1870) must be 0, and a 1 in any of them makes the frame fail. The values of all other overhead bits have no effect.
- R7: `idle` is written only in the cycle after a valid bit with `bit_pos` = 4759 is accepted while in frame. At all other times it holds its value, unless R8 applies.
- R8: `in_frame` low forces `idle` to 0 in the next cycle. A frame is evaluated only if its `bit_pos` 0 was accepted while in frame and `in_frame` stayed high until its end.
- R9: Cycles with `bit_valid` low are ignored. Gaps between bits do not change the result.
- R10: Every frame is judged on its own. Error counts and control-bit flags start over at `bit_pos` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_frame | input | 1 | High while the upstream framer holds frame alignment |
| bit_valid | input | 1 | Qualifies `rx_data` and `bit_pos` in this cycle |
| bit_pos | input | 13 | Index of the current bit within the M-frame, 0 to 4759 |
| rx_data | input | 1 | Received serial bit |
| idle | output | 1 | Idle-signal status of the last complete frame |

## Verification
Frames are sent with a chosen number of errored groups scattered over the whole frame. The corruption is injected in two ways: one flipped bit per group, or all four bits flipped. These two patterns separate counting groups from counting bits. Frames with 5 and 6 errored groups sit on either side of the limit, and a 12-group frame tests counter saturation. Frames with each control bit set, random values in the other overhead bits, random strobe gaps, a frame that starts partway through, and a mid-frame loss of frame check the position decode, the handling of gaps and when the status may change. A final run of random frames mixes all of these.

// File: rtl/ds3idl_pkg.sv
package ds3idl_pkg;

   // Per-bit decode of the M-frame position
   typedef struct packed {
      logic ovh;        // overhead bit of a block
      logic grp_last;   // last payload bit of a 4-bit group
      logic exp_bit;    // expected payload value for the idle sequence
      logic frm_start;  // first bit of the M-frame
      logic frm_last;   // last bit of the M-frame
   } slot_info_t;

   function automatic int frame_len(input int blk_bits, input int blk_per_sf, input int n_sf);
      return blk_bits * blk_per_sf * n_sf;
   endfunction

endpackage

// File: rtl/ds3idl_pos_decode.sv
module ds3idl_pos_decode
   import ds3idl_pkg::*;
#(
   parameter int BLOCK_BITS = 85,
   parameter int BLK_PER_SF = 8,
   parameter int N_SF       = 7,
   parameter int GROUP_BITS = 4,
   parameter int POS_W      = 13
) (
   input  logic [POS_W-1:0] bit_pos,
   output slot_info_t       slot,
   output logic [POS_W-1:0] blk_idx
);
   localparam int FRAME_BITS = frame_len(BLOCK_BITS, BLK_PER_SF, N_SF);
   localparam int HALF_GRP   = GROUP_BITS / 2;

   if ((BLOCK_BITS - 1) % GROUP_BITS != 0) begin : g_bad_group
      $error("payload length must be a whole number of groups");
   end
   if (FRAME_BITS > (1 << POS_W)) begin : g_bad_width
      $error("POS_W too narrow for the frame length");
   end

   logic [POS_W-1:0] offs;
   logic [POS_W-1:0] lane;

   always_comb begin
      offs           = bit_pos % POS_W'(BLOCK_BITS);
      blk_idx        = bit_pos / POS_W'(BLOCK_BITS);
      lane           = (offs - POS_W'(1)) % POS_W'(GROUP_BITS);
      slot.ovh       = (offs == '0);
      slot.grp_last  = (offs != '0) && (lane == POS_W'(GROUP_BITS - 1));
      slot.exp_bit   = (lane < POS_W'(HALF_GRP));
      slot.frm_start = (bit_pos == '0);
      slot.frm_last  = (bit_pos == POS_W'(FRAME_BITS - 1));
   end

endmodule

// File: rtl/ds3idl_group_check.sv
module ds3idl_group_check #(
   parameter int ERR_LIMIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_ok,
   input  logic rx_data,
   input  logic ovh,
   input  logic grp_last,
   input  logic exp_bit,
   input  logic frm_start,
   output logic over_limit
);
   localparam int CNT_W = $clog2(ERR_LIMIT + 2);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(ERR_LIMIT + 1);

   if (ERR_LIMIT < 0) begin : g_bad_limit
      $error("ERR_LIMIT must not be negative");
   end

   logic             grp_err_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_sum;
   logic             mism;
   logic             grp_hit;

   always_comb begin
      mism       = rx_data ^ exp_bit;
      grp_hit    = grp_last & (grp_err_q | mism);
      cnt_sum    = (grp_hit && cnt_q != SAT) ? cnt_q + CNT_W'(1) : cnt_q;
      over_limit = (cnt_sum > CNT_W'(ERR_LIMIT));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_err_q <= 1'b0;
         cnt_q     <= '0;
      end else if (bit_ok) begin
         if (frm_start) begin
            grp_err_q <= 1'b0;
            cnt_q     <= '0;
         end else if (ovh) begin
            grp_err_q <= 1'b0;
         end else if (grp_last) begin
            grp_err_q <= 1'b0;
            cnt_q     <= cnt_sum;
         end else begin
            grp_err_q <= grp_err_q | mism;
         end
      end
   end

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT);
   assert_grp_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ok && (ovh || grp_last)) |=> !grp_err_q);
   assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_ok |=> $stable(cnt_q));
   assert_frame_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ok && frm_start) |=> cnt_q == '0);

endmodule

// File: rtl/ds3idl_cbit_check.sv
module ds3idl_cbit_check #(
   parameter int POS_W      = 13,
   parameter int BLK_PER_SF = 8,
   parameter int IDLE_SF    = 2,
   parameter int N_CBIT     = 3,
   parameter int C_FIRST    = 2,
   parameter int C_STEP     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_ok,
   input  logic             rx_data,
   input  logic             ovh,
   input  logic             frm_start,
   input  logic [POS_W-1:0] blk_idx,
   output logic             c_bad
);
   if (C_FIRST + (N_CBIT - 1) * C_STEP >= BLK_PER_SF) begin : g_bad_slot
      $error("control-bit slot beyond the subframe");
   end

   logic [N_CBIT-1:0] bad_vec;

   for (genvar i = 0; i < N_CBIT; i++) begin : g_slot
      localparam int TARGET = IDLE_SF * BLK_PER_SF + C_FIRST + i * C_STEP;
      logic hit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
         end else if (bit_ok) begin
            if (frm_start) begin
               hit_q <= 1'b0;
            end else if (ovh && blk_idx == POS_W'(TARGET) && rx_data) begin
               hit_q <= 1'b1;
            end
         end
      end
      assign bad_vec[i] = hit_q;
   end

   assign c_bad = |bad_vec;

   assert_cflag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ok && frm_start) |=> bad_vec == '0);
   assert_cflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_bad && !(bit_ok && frm_start)) |=> c_bad);

endmodule

// File: rtl/ds3_idle_detect.sv
module ds3_idle_detect
   import ds3idl_pkg::*;
#(
   parameter int BLOCK_BITS = 85,
   parameter int BLK_PER_SF = 8,
   parameter int N_SF       = 7,
   parameter int GROUP_BITS = 4,
   parameter int ERR_LIMIT  = 5,
   parameter int IDLE_SF    = 2,
   parameter int N_CBIT     = 3,
   parameter int C_FIRST    = 2,
   parameter int C_STEP     = 2,
   parameter int POS_W      = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_frame,
   input  logic             bit_valid,
   input  logic [POS_W-1:0] bit_pos,
   input  logic             rx_data,
   output logic             idle
);
   localparam int FRAME_BITS = frame_len(BLOCK_BITS, BLK_PER_SF, N_SF);

   slot_info_t       slot;
   logic [POS_W-1:0] blk_idx;
   logic             bit_ok;
   logic             over_limit;
   logic             c_bad;
   logic             seen_q;
   logic             idle_q;

   assign bit_ok = bit_valid & in_frame;

   ds3idl_pos_decode #(
      .BLOCK_BITS(BLOCK_BITS), .BLK_PER_SF(BLK_PER_SF), .N_SF(N_SF),
      .GROUP_BITS(GROUP_BITS), .POS_W(POS_W)
   ) u_decode (
      .bit_pos(bit_pos),
      .slot   (slot),
      .blk_idx(blk_idx)
   );

   ds3idl_group_check #(
      .ERR_LIMIT(ERR_LIMIT)
   ) u_groups (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_ok    (bit_ok),
      .rx_data   (rx_data),
      .ovh       (slot.ovh),
      .grp_last  (slot.grp_last),
      .exp_bit   (slot.exp_bit),
      .frm_start (slot.frm_start),
      .over_limit(over_limit)
   );

   ds3idl_cbit_check #(
      .POS_W(POS_W), .BLK_PER_SF(BLK_PER_SF), .IDLE_SF(IDLE_SF),
      .N_CBIT(N_CBIT), .C_FIRST(C_FIRST), .C_STEP(C_STEP)
   ) u_cbits (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_ok   (bit_ok),
      .rx_data  (rx_data),
      .ovh      (slot.ovh),
      .frm_start(slot.frm_start),
      .blk_idx  (blk_idx),
      .c_bad    (c_bad)
   );

   // Frame-boundary status register; cleared whenever frame is lost
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         idle_q <= 1'b0;
      end else if (!in_frame) begin
         seen_q <= 1'b0;
         idle_q <= 1'b0;
      end else if (bit_valid) begin
         if (slot.frm_start) begin
            seen_q <= 1'b1;
         end
         if (slot.frm_last && seen_q) begin
            idle_q <= !over_limit && !c_bad;
         end
      end
   end

   assign idle = idle_q;

   assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> bit_pos < POS_W'(FRAME_BITS));
   assert_oof_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |=> !idle);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !(bit_valid && slot.frm_last)) |=> $stable(idle));
   assert_no_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && !idle) |=> !idle);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !idle);

endmodule

// File: tb/tb_ds3_idle_detect.sv
module tb_ds3_idle_detect;
   localparam int FRAME = 4760;
   localparam int NGRP  = 1176;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_frame = 1'b0;
   logic        bit_valid = 1'b0;
   logic [12:0] bit_pos = '0;
   logic        rx_data = 1'b0;
   logic        idle;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  prev_exp = 1'b0;
   bit  mark [NGRP];

   always #2 clk = ~clk;

   ds3_idle_detect dut (
      .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .bit_valid(bit_valid),
      .bit_pos(bit_pos), .rx_data(rx_data), .idle(idle)
   );

   function automatic bit expect_idle(input int nerr, input bit [2:0] cmask);
      return (nerr <= 5) && (cmask == 3'b000);
   endfunction

   function automatic int cslot(input int blk);
      if (blk == 18) return 0;
      if (blk == 20) return 1;
      if (blk == 22) return 2;
      return -1;
   endfunction

   task automatic check(input bit got, input bit exp, input string req);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: idle=%0b expected %0b", req, got, exp);
      end
   endtask

   // Sends bits start..4759; drop_at>=0 inserts a loss of frame before that bit
   task automatic send_frame(input int nerr, input bit multi, input bit [2:0] cmask,
                             input int start, input int drop_at, input int gap_pct,
                             input bit exp, input string req);
      int r;
      for (int g = 0; g < NGRP; g++) mark[g] = 1'b0;
      r = int'($urandom % 40);
      for (int i = 0; i < nerr; i++) mark[(r + i * 97) % NGRP] = 1'b1;
      for (int p = start; p < FRAME; p++) begin
         int blk  = p / 85;
         int offs = p % 85;
         bit b;
         if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
            @(negedge clk);
            bit_valid = 1'b0;
            rx_data   = 1'($urandom);
         end
         if (p == drop_at) begin
            @(negedge clk);
            in_frame  = 1'b0;
            bit_valid = 1'b0;
            @(negedge clk);
            check(idle, 1'b0, "R8 loss of frame clears");
            in_frame = 1'b1;
         end
         if (offs == 0) begin
            b = (cslot(blk) >= 0) ? cmask[cslot(blk)] : 1'($urandom);
         end else begin
            int k    = offs - 1;
            int g    = blk * 21 + k / 4;
            int lane = k % 4;
            b = ((k % 4) < 2);
            if (mark[g] && (multi || lane == g % 4)) b = ~b;
         end
         @(negedge clk);
         if (p == 2500 && (drop_at < 0 || drop_at > 2500))
            check(idle, prev_exp, "R7 status held mid-frame");
         bit_valid = 1'b1;
         bit_pos   = 13'(p);
         rx_data   = b;
      end
      @(negedge clk);
      bit_valid = 1'b0;
      @(negedge clk);
      check(idle, exp, req);
      prev_exp = exp;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: idle=%0b expected run end", idle);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      check(idle, 1'b0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check(idle, 1'b0, "R1 after reset");
      in_frame = 1'b1;

      send_frame(0, 0, 3'b000, 3000, -1, 0, 1'b0, "R8 partial frame not evaluated");
      send_frame(0, 0, 3'b000, 0, -1, 0, expect_idle(0, 3'b000), "R2 clean frame");
      send_frame(5, 0, 3'b000, 0, -1, 0, expect_idle(5, 3'b000), "R4 five errored groups");
      send_frame(5, 1, 3'b000, 0, -1, 0, expect_idle(5, 3'b000), "R3 full-group errors count once");
      send_frame(6, 0, 3'b000, 0, -1, 0, expect_idle(6, 3'b000), "R5 six errored groups");
      send_frame(0, 0, 3'b000, 0, -1, 0, expect_idle(0, 3'b000), "R10 recovery after bad frame");
      send_frame(3, 1, 3'b000, 0, -1, 30, expect_idle(3, 3'b000), "R9 gaps ignored");
      send_frame(0, 0, 3'b001, 0, -1, 0, expect_idle(0, 3'b001), "R6 first control bit set");
      send_frame(0, 0, 3'b000, 0, -1, 0, expect_idle(0, 3'b000), "R10 clean after control fail");
      send_frame(0, 0, 3'b100, 0, -1, 0, expect_idle(0, 3'b100), "R6 third control bit set");
      send_frame(2, 0, 3'b000, 0, -1, 0, expect_idle(2, 3'b000), "R6 other overhead ignored");
      send_frame(0, 0, 3'b010, 0, -1, 0, expect_idle(0, 3'b010), "R6 second control bit set");
      send_frame(0, 0, 3'b000, 0, 3000, 0, 1'b0, "R8 frame with loss not evaluated");
      send_frame(0, 0, 3'b000, 0, -1, 0, expect_idle(0, 3'b000), "R2 clean after loss");
      send_frame(12, 1, 3'b000, 0, -1, 0, expect_idle(12, 3'b000), "R5 saturating error count");

      for (int f = 0; f < 6; f++) begin
         int       ne = int'($urandom % 10);
         bit       mu = 1'($urandom);
         bit [2:0] cm = ($urandom % 4 == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
         send_frame(ne, mu, cm, 0, -1, 10, expect_idle(ne, cm), "R4 R5 R6 R9 random frame");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule